// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block drives the reset of a processor from two causes: a digital "supply below threshold" flag produced by an external comparator, and an active-low manual reset line such as a pushbutton. While either cause is present, reset is held. Once both have cleared, reset is held for a further fixed number of clock cycles before it releases. Any new low-supply event or button press during that hold starts the full hold again.

Reset is available in two polarities, one the exact inverse of the other. The supply flag reaches the outputs through a combinational path, so reset asserts in the same cycle the flag rises. Both causes also pass through a two-flop synchronizer before they reach the hold counter. The manual line acts only through that synchronizer, so a press shorter than a clock period that misses every sampling edge has no effect. The hold length is given as a parameter in clock cycles, which lets a nominal 200 ms interval be scaled down for simulation. A second parameter sets a floor that the hold never goes below.

Top module: `rst_supervisor`

## Requirements
- R1: `rst_out` is 1 in the same cycle that `supply_low` is 1, before any clock edge, and stays 1 for as long as `supply_low` stays 1.
- R2: After the last cycle in which a cause is present, `rst_out` stays 1 for exactly STRETCH_CYCLES+1 clock edges and goes to 0 after edge STRETCH_CYCLES+2, counted from the first edge at which the cause has cleared. The extra two edges are the synchronizer.
- R3: `rst_out_n` is always the logical inverse of `rst_out`.
- R4: `rst_out` never falls before MIN_CYCLES edges have passed with no cause present. A supply blip lasting a single cycle still yields a full hold.
- R5: A supply-low event that arrives while a hold is running restarts the hold at its full length, with the count taken from the end of the new event.
- R6: When `mr_n` is 0, `rst_out` becomes 1 after the second clock edge, not after the first.
- R7: A low pulse on `mr_n` that starts and ends between two rising clock edges is ignored, and `rst_out` stays 0.
- R8: While `arst_n` is 0, `rst_out` is 1. After `arst_n` rises, `rst_out` stays 1 for STRETCH_CYCLES-1 edges and falls after edge STRETCH_CYCLES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| arst_n | input | 1 | Asynchronous active-low power-on reset of the logic |
| supply_low | input | 1 | 1 while the supply is below threshold |
| mr_n | input | 1 | Active-low manual reset request |
| rst_out | output | 1 | Active-high processor reset |
| rst_out_n | output | 1 | Active-low processor reset, inverse of `rst_out` |

## Verification
The bench counts edges exactly at each release. A counter that is off by one, or a missing synchronizer stage, moves the falling edge of `rst_out` by one cycle and is reported. A brown-out injected partway through a hold would, in a design that resumed the old count instead of reloading it, release reset several cycles early. A single-cycle supply blip and a sub-cycle button glitch probe both sides of the minimum hold: a design that sized the hold to the event length would release too soon, and one that sampled `mr_n` asynchronously would assert reset on the glitch. The supply test samples just after the flag rises, with no edge in between, and catches a design that routes the flag only through the synchronizer.

// File: rtl/rstsup_pkg.sv
package rstsup_pkg;
  localparam int REQ_SUPPLY = 0;
  localparam int REQ_MANUAL = 1;
  localparam int NUM_REQ    = 2;
  localparam int SYNC_DEPTH = 2;

  function automatic int hold_len(input int nominal, input int floor_len);
    return (nominal >= floor_len) ? nominal : floor_len;
  endfunction
endpackage

// File: rtl/rstsup_sync.sv
module rstsup_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (gi == 0) begin : g_first
        assign stage_d = d_async;
      end else begin : g_rest
        assign stage_d = stage_q[gi-1];
      end
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stage_q[gi] <= '0;
        else         stage_q[gi] <= stage_d;
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/rstsup_stretch.sv
module rstsup_stretch #(
  parameter int HOLD_CYCLES = 200
) (
  input  logic clk,
  input  logic arst_n,
  input  logic load,
  output logic busy
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] FULL = CW'(HOLD_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (load)             cnt_d = FULL;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     cnt_q <= FULL;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/rstsup_outstage.sv
module rstsup_outstage (
  input  logic arst_n,
  input  logic supply_raw,
  input  logic req_any,
  input  logic busy,
  output logic rst_hi,
  output logic rst_lo
);
  logic hold;

  always_comb begin
    hold   = supply_raw || req_any || busy || !arst_n;
    rst_hi = hold;
    rst_lo = !hold;
  end
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int STRETCH_CYCLES = 200,
  parameter int MIN_CYCLES     = 140
) (
  input  logic clk,
  input  logic arst_n,
  input  logic supply_low,
  input  logic mr_n,
  output logic rst_out,
  output logic rst_out_n
);
  import rstsup_pkg::*;

  localparam int HOLD = hold_len(STRETCH_CYCLES, MIN_CYCLES);

  logic [NUM_REQ-1:0] req_raw;
  logic [NUM_REQ-1:0] req_sync;
  logic               req_any;
  logic               busy;

  always_comb begin
    req_raw             = '0;
    req_raw[REQ_SUPPLY] = supply_low;
    req_raw[REQ_MANUAL] = !mr_n;
  end

  rstsup_sync #(.WIDTH(NUM_REQ), .STAGES(SYNC_DEPTH)) u_sync (
    .clk     (clk),
    .arst_n  (arst_n),
    .d_async (req_raw),
    .q_sync  (req_sync)
  );

  assign req_any = |req_sync;

  rstsup_stretch #(.HOLD_CYCLES(HOLD)) u_stretch (
    .clk    (clk),
    .arst_n (arst_n),
    .load   (req_any),
    .busy   (busy)
  );

  rstsup_outstage u_out (
    .arst_n     (arst_n),
    .supply_raw (supply_low),
    .req_any    (req_any),
    .busy       (busy),
    .rst_hi     (rst_out),
    .rst_lo     (rst_out_n)
  );
endmodule

// File: rtl/rstsup_checker.sv
module rstsup_checker #(
  parameter int STRETCH_CYCLES = 200,
  parameter int MIN_CYCLES     = 140
) (
  input logic clk,
  input logic arst_n,
  input logic supply_low,
  input logic req_any,
  input logic rst_out,
  input logic rst_out_n
);
  localparam int QW = $clog2(STRETCH_CYCLES + 1);
  localparam logic [QW-1:0] QMAX = QW'(STRETCH_CYCLES);

  logic [QW-1:0] quiet_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)          quiet_q <= '0;
    else if (req_any)     quiet_q <= '0;
    else if (quiet_q != QMAX) quiet_q <= quiet_q + 1'b1;
  end

  // R1: a supply-low level always shows on the reset output
  p_hold_low_r1: assert property (@(posedge clk) disable iff (!arst_n)
    supply_low |-> rst_out);

  // R2: reset holds while the quiet window is shorter than the stretch
  p_stretch_hold_r2: assert property (@(posedge clk) disable iff (!arst_n)
    (!req_any && (quiet_q < QMAX)) |-> rst_out);

  // R2: reset releases once the full quiet window has passed
  p_release_r2: assert property (@(posedge clk) disable iff (!arst_n)
    (!req_any && !supply_low && (quiet_q == QMAX)) |-> !rst_out);

  // R3: the two outputs are inverses of each other
  p_complement_r3: assert property (@(posedge clk) disable iff (!arst_n)
    rst_out_n == !rst_out);

  // R4: a released reset implies at least the minimum quiet window
  p_min_stretch_r4: assert property (@(posedge clk) disable iff (!arst_n)
    !rst_out |-> (32'(quiet_q) >= MIN_CYCLES));

  // R5: a synchronized request keeps reset asserted in the following cycle
  p_restart_r5: assert property (@(posedge clk) disable iff (!arst_n)
    req_any |=> rst_out);
endmodule

bind rst_supervisor rstsup_checker #(
  .STRETCH_CYCLES (STRETCH_CYCLES),
  .MIN_CYCLES     (MIN_CYCLES)
) u_chk (
  .clk        (clk),
  .arst_n     (arst_n),
  .supply_low (supply_low),
  .req_any    (req_any),
  .rst_out    (rst_out),
  .rst_out_n  (rst_out_n)
);

// File: tb/sim_rst_supervisor.sv
module sim_rst_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int S   = 20;
  localparam int MIN = 14;

  logic clk = 1'b0;
  logic arst_n, supply_low, mr_n;
  logic rst_out, rst_out_n;
  int   n_checks = 0;
  int   n_fail   = 0;

  rst_supervisor #(.STRETCH_CYCLES(S), .MIN_CYCLES(MIN)) u0 (
    .clk(clk), .arst_n(arst_n), .supply_low(supply_low), .mr_n(mr_n),
    .rst_out(rst_out), .rst_out_n(rst_out_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic exp_rst);
    n_checks++;
    if (rst_out !== exp_rst) begin
      n_fail++;
      $display("FAIL %s rst_out actual=%b expected=%b t=%0t", req, rst_out, exp_rst, $time);
    end
    n_checks++;
    if (rst_out_n !== !exp_rst) begin
      n_fail++;
      $display("FAIL R3 rst_out_n actual=%b expected=%b t=%0t", rst_out_n, !exp_rst, $time);
    end
  endtask

  task automatic t_power_on;
    arst_n = 1'b0; supply_low = 1'b0; mr_n = 1'b1;
    step(2);
    chk("R8", 1'b1);
    arst_n = 1'b1;
    step(S-1);
    chk("R8", 1'b1);
    step(1);
    chk("R8", 1'b0);
  endtask

  task automatic t_supply_hold;
    supply_low = 1'b1;
    #1 chk("R1", 1'b1);
    step(6);
    chk("R1", 1'b1);
    supply_low = 1'b0;
    step(S+1);
    chk("R2", 1'b1);
    step(1);
    chk("R2", 1'b0);
  endtask

  task automatic t_brownout;
    supply_low = 1'b1;
    step(3);
    supply_low = 1'b0;
    step(8);
    chk("R5", 1'b1);
    supply_low = 1'b1;
    step(2);
    supply_low = 1'b0;
    step(S+1);
    chk("R5", 1'b1);
    step(1);
    chk("R5", 1'b0);
  endtask

  task automatic t_blip_min;
    supply_low = 1'b1;
    step(1);
    supply_low = 1'b0;
    step(MIN);
    chk("R4", 1'b1);
    step(S+2-MIN);
    chk("R4", 1'b0);
  endtask

  task automatic t_manual;
    mr_n = 1'b0;
    step(1);
    chk("R6", 1'b0);
    step(1);
    chk("R6", 1'b1);
    step(4);
    mr_n = 1'b1;
    step(S+1);
    chk("R6", 1'b1);
    step(1);
    chk("R6", 1'b0);
  endtask

  task automatic t_glitch;
    mr_n = 1'b0;
    #(CLK_PERIOD/4) mr_n = 1'b1;
    step(1);
    chk("R7", 1'b0);
    step(3);
    chk("R7", 1'b0);
  endtask

  initial begin
    t_power_on();
    t_supply_hold();
    t_brownout();
    t_blip_min();
    t_manual();
    t_glitch();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired t=%0t", $time);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule